// File: doc/BRIEF.md
# Exhaustive Counter Logic Self-Test

This wrapper sits around a block of purely combinational logic and lets that block test itself without any pattern source or comparator outside the chip. The tester only supplies the clock, raises the test-mode select and pulses start. A binary counter then steps through every combination of the block's inputs, one per clock. A register captures each response, and a multiple-input signature register (MISR) folds the captured responses into one compacted value.

When the counter has wrapped exactly once, the wrapper raises a done flag. It then reports the result in two forms: a single go/no-go pin, which compares the signature with a build-time expected value, and the full signature word for closer diagnosis. While test mode is low, the functional inputs go straight through to the logic under test, and every piece of test state keeps its value.

Top module: `lbist_exhaustive`

## Requirements
- R1: While `test_mode` is 0, `cut_in` equals `func_in` in the same cycle, for any value of `func_in`.
- R2: After a start, `cut_in` shows the counter value. It takes 0, 1, 2 and so on up to 2^IN_W-1, one value per clock, and the value 0 is visible in the cycle that follows the start edge. IN_W must lie between 1 and 20.
- R3: A clock edge with `start`=1 and `test_mode`=1 restarts the test. The counter goes to 0, `signature` goes to SEED (default 16'hFFFF) and `done` goes to 0. A `start` seen while `test_mode`=0 is ignored. In the idle state the counter does not advance.
- R4: The response to each pattern is registered at the end of that pattern's cycle and folded into the signature one cycle later. `done` rises on the (2^IN_W+1)-th clock edge after the start edge, which is after exactly one wrap of the counter. From then on the counter rests at 0, and `done` and `signature` hold until the next start or reset.
- R5: Each fold computes signature_next = (signature << 1) XOR (POLY if signature[SIG_W-1] is 1, else 0) XOR R. POLY defaults to 16'h100B, which is x^16+x^12+x^3+x+1 with the top term implied. R is the captured response, with response bit i XORed into signature bit (i mod SIG_W).
- R6: `go` is 1 exactly when `done` is 1 and `signature` equals the parameter EXPECTED. A single corrupted response anywhere in the run leaves `go` at 0.
- R7: While `test_mode` is 0 during a run, the counter, the captured response, the signature and `done` keep their values. When `test_mode` returns to 1, the run resumes and ends with the same signature as an uninterrupted run.
- R8: A synchronous active-high `rst` sets the counter to 0, `signature` to SEED, `done` to 0 and `go` to 0, even in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock supplied by the tester |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | 1 selects self-test; 0 selects functional pass-through and freezes the test state |
| start | input | 1 | Restarts the exhaustive run when sampled high in test mode |
| func_in | input | IN_W | Functional inputs of the logic under test |
| cut_in | output | IN_W | Drive to the logic under test's inputs |
| cut_resp | input | OUT_W | Outputs returned from the logic under test |
| done | output | 1 | Run complete; the signature is final |
| go | output | 1 | Go/no-go result, valid only while done is 1 |
| signature | output | SIG_W | Compacted MISR signature |

## Verification
The bench models the logic under test and the MISR rule from the requirements, so it knows the exact signature for a clean run and for a run with one faulty response. A design that drops the first or the last pattern, or folds the response one cycle early, ends with the wrong signature. Such a design also raises `done` on the wrong edge, and the bench checks that edge cycle by cycle. Further runs restart the test mid-run, apply a reset mid-run, pause by dropping `test_mode`, and pulse `start` outside test mode. A design that leaks state across a pause, ignores a restart or reseed, or obeys `start` outside test mode gives a changed signature, a lost `done`, or a counter that has moved. A fault injected at a single pattern must clear `go`; a comparison that is too loose would leave it set.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    localparam int LBIST_MAX_IN_W = 20;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DONE  = 2'd3
    } lbist_state_e;

    typedef struct packed {
        logic clear;
        logic step;
        logic capture;
        logic fold;
    } lbist_ctl_t;

endpackage

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
    import lbist_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         test_mode,
    input  logic         start,
    input  logic         wrap,
    output lbist_ctl_t   ctl,
    output lbist_state_e state,
    output logic         done
);
    lbist_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ctl     = '0;
        if (test_mode) begin
            if (start) begin
                ctl.clear = 1'b1;
                state_d   = ST_RUN;
            end else begin
                case (state_q)
                    ST_RUN: begin
                        ctl.step    = 1'b1;
                        ctl.capture = 1'b1;
                        ctl.fold    = 1'b1;
                        if (wrap) state_d = ST_FLUSH;
                    end
                    ST_FLUSH: begin
                        ctl.fold = 1'b1;
                        state_d  = ST_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign state = state_q;
    assign done  = (state_q == ST_DONE);
endmodule

// File: rtl/lbist_counter.sv
module lbist_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else if (step)    cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;
    assign wrap  = &cnt_q;
endmodule

// File: rtl/lbist_capture.sv
module lbist_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         capture,
    input  logic [W-1:0] resp_in,
    output logic [W-1:0] resp_q,
    output logic         valid
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            resp_q <= '0;
            valid  <= 1'b0;
        end else if (capture) begin
            resp_q <= resp_in;
            valid  <= 1'b1;
        end
    end
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
    parameter int              DATA_W = 8,
    parameter int              SIG_W  = 16,
    parameter logic [SIG_W-1:0] POLY  = 16'h100B,
    parameter logic [SIG_W-1:0] SEED  = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              fold_en,
    input  logic [DATA_W-1:0] data,
    output logic [SIG_W-1:0]  sig
);
    logic [SIG_W-1:0] sig_q, folded, sig_next;

    always_comb begin
        folded = '0;
        for (int i = 0; i < DATA_W; i++) begin
            folded[i % SIG_W] = folded[i % SIG_W] ^ data[i];
        end
    end

    assign sig_next = {sig_q[SIG_W-2:0], 1'b0}
                    ^ (sig_q[SIG_W-1] ? POLY : '0)
                    ^ folded;

    always_ff @(posedge clk) begin
        if (rst || clear) sig_q <= SEED;
        else if (fold_en) sig_q <= sig_next;
    end

    assign sig = sig_q;
endmodule

// File: rtl/lbist_exhaustive.sv
module lbist_exhaustive
    import lbist_pkg::*;
#(
    parameter int               IN_W     = 8,
    parameter int               OUT_W    = 8,
    parameter int               SIG_W    = 16,
    parameter logic [SIG_W-1:0] POLY     = 16'h100B,
    parameter logic [SIG_W-1:0] SEED     = 16'hFFFF,
    parameter logic [SIG_W-1:0] EXPECTED = 16'h0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             test_mode,
    input  logic             start,
    input  logic [IN_W-1:0]  func_in,
    output logic [IN_W-1:0]  cut_in,
    input  logic [OUT_W-1:0] cut_resp,
    output logic             done,
    output logic             go,
    output logic [SIG_W-1:0] signature
);
    generate
        if (IN_W < 1 || IN_W > LBIST_MAX_IN_W) begin : g_bad_width
            $error("IN_W out of range for exhaustive self-test");
        end
    endgenerate

    lbist_ctl_t       ctl;
    lbist_state_e     state_q;
    logic [IN_W-1:0]  cnt_q;
    logic             wrap;
    logic [OUT_W-1:0] resp_q;
    logic             cap_valid;

    lbist_ctrl u_ctrl (
        .clk(clk), .rst(rst), .test_mode(test_mode), .start(start),
        .wrap(wrap), .ctl(ctl), .state(state_q), .done(done)
    );

    lbist_counter #(.W(IN_W)) u_cnt (
        .clk(clk), .rst(rst), .clear(ctl.clear), .step(ctl.step),
        .count(cnt_q), .wrap(wrap)
    );

    lbist_capture #(.W(OUT_W)) u_cap (
        .clk(clk), .rst(rst), .clear(ctl.clear), .capture(ctl.capture),
        .resp_in(cut_resp), .resp_q(resp_q), .valid(cap_valid)
    );

    lbist_misr #(.DATA_W(OUT_W), .SIG_W(SIG_W), .POLY(POLY), .SEED(SEED)) u_misr (
        .clk(clk), .rst(rst), .clear(ctl.clear),
        .fold_en(ctl.fold & cap_valid), .data(resp_q), .sig(signature)
    );

    assign cut_in = test_mode ? cnt_q : func_in;
    assign go     = done && (signature == EXPECTED);
endmodule

// File: rtl/lbist_exhaustive_chk.sv
module lbist_exhaustive_chk
    import lbist_pkg::*;
#(
    parameter int               IN_W  = 8,
    parameter int               SIG_W = 16,
    parameter logic [SIG_W-1:0] SEED  = 16'hFFFF
) (
    input logic             clk,
    input logic             rst,
    input logic             test_mode,
    input logic             start,
    input logic             done,
    input logic [SIG_W-1:0] signature,
    input logic [IN_W-1:0]  cnt_q,
    input lbist_state_e     state_q
);
    // R2: the counter moves up by one on every running cycle
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && test_mode && !start) |=> cnt_q == IN_W'($past(cnt_q) + 1'b1));

    // R3: a start in test mode reseeds the signature and clears done
    a_r3_start_reseeds: assert property (@(posedge clk) disable iff (rst)
        (start && test_mode) |=> (signature == SEED && !done));

    // R4: done rises only after the flush cycle, with the counter wrapped to 0
    a_r4_done_after_wrap: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (cnt_q == '0 && $past(state_q) == ST_FLUSH));

    // R7: with test mode low the test state is frozen
    a_r7_pause_holds: assert property (@(posedge clk) disable iff (rst)
        !test_mode |=> ($stable(signature) && $stable(done) && $stable(cnt_q)));

    // R4: once done, the result holds until a new start
    a_r4_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !(start && test_mode)) |=> (done && $stable(signature)));
endmodule

bind lbist_exhaustive lbist_exhaustive_chk #(
    .IN_W(IN_W), .SIG_W(SIG_W), .SEED(SEED)
) u_chk (
    .clk(clk), .rst(rst), .test_mode(test_mode), .start(start),
    .done(done), .signature(signature), .cnt_q(cnt_q), .state_q(state_q)
);

// File: tb/tb_lbist_exhaustive.sv
`timescale 1ns/1ps
module tb_lbist_exhaustive;
    localparam int N = 256;

    function automatic logic [7:0] cut_model(logic [7:0] x);
        return {x[6:0], x[7]} ^ (x & {x[3:0], x[7:4]}) ^ 8'hA5;
    endfunction

    function automatic logic [15:0] misr_step(logic [15:0] s, logic [7:0] r);
        return {s[14:0], 1'b0} ^ (s[15] ? 16'h100B : 16'h0000) ^ {8'h00, r};
    endfunction

    function automatic logic [15:0] run_sig(bit faulty);
        logic [15:0] s = 16'hFFFF;
        for (int i = 0; i < N; i++) begin
            logic [7:0] r = cut_model(i[7:0]);
            if (faulty && i == 8'h5A) r = r ^ 8'h01;
            s = misr_step(s, r);
        end
        return s;
    endfunction

    localparam logic [15:0] GOLDEN = run_sig(1'b0);
    localparam logic [15:0] FAULTY = run_sig(1'b1);

    // stimulus in the high byte, expected cut_in in the low byte
    localparam logic [15:0] PASS_VEC [8] = '{
        16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A,
        16'h0101, 16'h8080, 16'h3C3C, 16'hC3C3
    };

    logic clk = 1'b0, rst = 1'b1, test_mode = 1'b0, start = 1'b0, fault_en = 1'b0;
    logic [7:0] func_in = 8'h00, cut_in, cut_resp;
    logic done, go;
    logic [15:0] signature;
    int errors = 0, checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign cut_resp = cut_model(cut_in) ^ ((fault_en && cut_in == 8'h5A) ? 8'h01 : 8'h00);

    lbist_exhaustive #(.EXPECTED(GOLDEN)) dut (
        .clk(clk), .rst(rst), .test_mode(test_mode), .start(start),
        .func_in(func_in), .cut_in(cut_in), .cut_resp(cut_resp),
        .done(done), .go(go), .signature(signature)
    );

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [15:0] held;
        bit seq_ok;
        wait_cycles(3);
        test_mode = 1'b1;
        #1;
        // R8: reset state
        chk(done == 1'b0, "R8", "done in reset", done, 0);
        chk(go == 1'b0, "R8", "go in reset", go, 0);
        chk(signature == 16'hFFFF, "R8", "seed in reset", signature, 16'hFFFF);
        chk(cut_in == 8'h00, "R8", "counter in reset", cut_in, 0);
        @(negedge clk) rst = 1'b0;

        // R1: pass-through table
        test_mode = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) func_in = PASS_VEC[i][15:8];
            #1;
            chk(cut_in == PASS_VEC[i][7:0], "R1", "pass-through", cut_in, PASS_VEC[i][7:0]);
        end

        // R3: start ignored outside test mode; idle counter does not move
        pulse_start();
        wait_cycles(3);
        test_mode = 1'b1;
        wait_cycles(3);
        chk(done == 1'b0, "R3", "done after ignored start", done, 0);
        chk(signature == 16'hFFFF, "R3", "signature after ignored start", signature, 16'hFFFF);
        chk(cut_in == 8'h00, "R3", "idle counter frozen", cut_in, 0);

        // R2/R4/R5/R6: full clean run
        pulse_start();
        seq_ok = 1'b1;
        for (int k = 0; k < N; k++) begin
            if (cut_in != k[7:0]) seq_ok = 1'b0;
            @(negedge clk);
        end
        chk(seq_ok, "R2", "counter visits every value in order", seq_ok, 1);
        chk(done == 1'b0, "R4", "done not yet after N edges", done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R4", "done after N+1 edges", done, 1);
        chk(signature == GOLDEN, "R5", "clean signature", signature, GOLDEN);
        chk(go == 1'b1, "R6", "go on clean run", go, 1);
        held = signature;
        wait_cycles(5);
        chk(done == 1'b1 && signature == held, "R4", "result holds", signature, held);
        chk(cut_in == 8'h00, "R4", "counter rests at 0", cut_in, 0);

        // R6: single fault at pattern 5A clears go
        fault_en = 1'b1;
        pulse_start();
        #1;
        chk(done == 1'b0 && go == 1'b0, "R6", "go low while running", go, 0);
        wait_cycles(N + 1);
        chk(done == 1'b1, "R6", "done on faulty run", done, 1);
        chk(signature == FAULTY, "R5", "faulty signature", signature, FAULTY);
        chk(go == 1'b0, "R6", "go low on faulty run", go, 0);
        fault_en = 1'b0;

        // R7: pause mid-run
        pulse_start();
        wait_cycles(100);
        test_mode = 1'b0;
        func_in = 8'h3C;
        held = signature;
        wait_cycles(20);
        chk(signature == held && done == 1'b0, "R7", "signature frozen in pause", signature, held);
        chk(cut_in == 8'h3C, "R7", "pass-through during pause", cut_in, 8'h3C);
        test_mode = 1'b1;
        #1;
        chk(cut_in == 8'd100, "R7", "counter resumes where it stopped", cut_in, 100);
        wait_cycles(N + 1 - 100);
        chk(done == 1'b1 && signature == GOLDEN, "R7", "resumed signature", signature, GOLDEN);

        // R3: restart mid-run
        pulse_start();
        wait_cycles(50);
        pulse_start();
        #1;
        chk(cut_in == 8'h00 && signature == 16'hFFFF, "R3", "restart reseeds", signature, 16'hFFFF);
        wait_cycles(N + 1);
        chk(done == 1'b1 && go == 1'b1, "R3", "restart run passes", go, 1);
        chk(signature == GOLDEN, "R3", "restart signature", signature, GOLDEN);

        // R8: reset mid-run
        pulse_start();
        wait_cycles(40);
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        #1;
        chk(signature == 16'hFFFF && done == 1'b0 && go == 1'b0, "R8", "mid-run reset", signature, 16'hFFFF);
        chk(cut_in == 8'h00, "R8", "counter after mid-run reset", cut_in, 0);
        wait_cycles(5);
        chk(cut_in == 8'h00 && done == 1'b0, "R8", "idle after reset", cut_in, 0);

        summary();
    end
endmodule